// File: doc/BRIEF.md
# Programmable Sum-of-Products Array with Output Cells

This block is a small field-configurable logic device. Each output is a sum of a fixed group of product terms. Each product term is an AND of any chosen literals. A literal is a primary input, a feedback signal, or the complement of either. Every output passes through an output cell with three modes: input pin, combinational driver, or clocked driver. The value each cell feeds back into the product-term array lets one output serve as a literal of another, which builds multilevel logic.

All connection bits and cell mode bits sit in one configuration vector. The vector is loaded one bit per clock through a serial port while a load-enable input is high, and the logic is idle during that time. The pad is split into separate signals: the block gives a drive value and a drive enable for each output pin, and takes back the value seen on that pin.

Top module: `pal_array`

## Requirements
- R1: While `cfg_load` is high, each rising clock edge shifts `cfg_bit` into the top of the configuration vector and moves every bit one place down, so after TOTAL loads the bit entered first sits at index 0. While `cfg_load` is low, the vector holds its value whatever `cfg_bit` does.
- R2: A synchronous active-low reset clears the configuration vector and every output register to 0. After reset, `pad_oe` and `pad_drive` are all 0.
- R3: While `cfg_load` is high, `pad_oe` is all 0 and every output register is held at 0.
- R4: Product term t of output o uses configuration bits starting at (o*N_PT+t)*2*N_SIG. Within that group, offset 2*s connects signal s in true form and offset 2*s+1 connects it in complemented form. Signal s is `in_sig[s]` for s < N_IN, and the feedback of output s-N_IN otherwise. A term is the AND of its connected literals.
- R5: A product term with no connected literal evaluates to 0. An output whose terms are all unconnected is 0.
- R6: Output o is the OR of terms o*N_PT through o*N_PT+N_PT-1 only. Terms of other outputs never affect it.
- R7: The mode of output o is bit AND_BITS+2*o+1 (drive enable) and bit AND_BITS+2*o (clocked select), where AND_BITS = N_OUT*N_PT*2*N_SIG. With drive enable 0, `pad_oe[o]` is 0, `pad_drive[o]` is 0, and the feedback of output o is `pad_in[o]`.
- R8: With enable 1 and select 0, `pad_oe[o]` is 1 and `pad_drive[o]` shows the sum in the same cycle.
- R9: With enable 1 and select 1, `pad_oe[o]` is 1 and `pad_drive[o]` is the output register. The register takes the sum at each rising edge, so the pin changes only after an edge.
- R10: When drive enable is 1, the feedback of output o is its output register, which holds the sum sampled at the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Configuration load enable; holds the logic idle |
| cfg_bit | input | 1 | Serial configuration data |
| in_sig | input | N_IN | Dedicated logic inputs |
| pad_in | input | N_OUT | Value seen on each output pin |
| pad_drive | output | N_OUT | Value driven onto each output pin |
| pad_oe | output | N_OUT | Drive enable for each output pin |

## Verification
The assertions assume that `cfg_load` is low during normal operation and that logic inputs change only away from the rising edge. They also assume that a clocked-output check applies only after a full cycle out of reset and out of loading in the same mode. The stimulus keeps to this. It changes configuration only inside a full serial load framed by `cfg_load`, drives all logic inputs on the falling edge, and runs at least one idle cycle after each load before it compares clocked outputs. Feedback is taken only from registers or from pin inputs, so no stimulus can set up a combinational loop.

// File: rtl/pal_pkg.sv
// Shared types for the programmable sum-of-products array.
// Assumes: mode bit 1 is drive enable and mode bit 0 is clocked select.
package pal_pkg;
    typedef enum logic [1:0] {
        CELL_PIN_A = 2'b00,
        CELL_PIN_B = 2'b01,
        CELL_COMB  = 2'b10,
        CELL_REG   = 2'b11
    } cell_mode_e;
endpackage

// File: rtl/pal_cfg_shift.sv
// Serial configuration register. New bits enter at the top and move down.
// Assumes: the caller holds the logic idle while load is high.
module pal_cfg_shift #(
    parameter int TOTAL = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             din,
    output logic [TOTAL-1:0] cfg
);
    // Clear on reset, shift one place per edge while loading.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg <= '0;
        else if (load)
            cfg <= {din, cfg[TOTAL-1:1]};
    end

    assert_shift_in_R1: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cfg[TOTAL-1] == $past(din));
    assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(cfg));
endmodule

// File: rtl/pal_and_or.sv
// Programmable AND array followed by a fixed OR array.
// Assumes: every signal is offered in true and complemented form, and each
// output owns a contiguous group of N_PT terms.
module pal_and_or #(
    parameter int N_SIG = 12,
    parameter int N_OUT = 4,
    parameter int N_PT  = 4,
    localparam int LIT      = 2 * N_SIG,
    localparam int N_TERM   = N_OUT * N_PT,
    localparam int AND_BITS = N_TERM * LIT
) (
    input  logic [AND_BITS-1:0] and_cfg,
    input  logic [N_SIG-1:0]    sig,
    output logic [N_OUT-1:0]    sum
);
    logic [LIT-1:0]    lit;
    logic [N_TERM-1:0] term;

    // Interleave true and complemented forms of each signal.
    for (genvar s = 0; s < N_SIG; s++) begin : g_lit
        assign lit[2*s]   = sig[s];
        assign lit[2*s+1] = ~sig[s];
    end

    // One product term per group of LIT connection bits; empty terms give 0.
    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        logic [LIT-1:0] conn;
        assign conn    = and_cfg[t*LIT +: LIT];
        assign term[t] = (|conn) & (&(lit | ~conn));
    end

    // Fixed OR of each output's own group of terms.
    for (genvar o = 0; o < N_OUT; o++) begin : g_or
        assign sum[o] = |term[o*N_PT +: N_PT];

        // Unconnected group must give a zero sum.
        always_comb begin
            if (and_cfg[o*N_PT*LIT +: N_PT*LIT] == '0)
                assert_empty_group_R5: assert (sum[o] == 1'b0);
        end
    end
endmodule

// File: rtl/pal_cell.sv
// Output cell: pin input, combinational driver, or clocked driver.
// Assumes: idle is high during configuration loading; feedback never
// carries the combinational sum, so no loop can form through the array.
module pal_cell
    import pal_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idle,
    input  logic [1:0] mode,
    input  logic       sum,
    input  logic       pad_in,
    output logic       pad_drive,
    output logic       pad_oe,
    output logic       fb
);
    logic q;

    // Output register: cleared by reset or loading, else samples the sum.
    always_ff @(posedge clk) begin
        if (!rst_n || idle)
            q <= 1'b0;
        else
            q <= sum;
    end

    // Pin drive value and enable chosen by mode; forced off while idle.
    always_comb begin
        pad_oe    = 1'b0;
        pad_drive = 1'b0;
        if (!idle) begin
            case (cell_mode_e'(mode))
                CELL_COMB: begin pad_oe = 1'b1; pad_drive = sum; end
                CELL_REG:  begin pad_oe = 1'b1; pad_drive = q;   end
                default:   begin pad_oe = 1'b0; pad_drive = 1'b0; end
            endcase
        end
    end

    // Feedback: the pin when undriven, the register otherwise.
    assign fb = mode[1] ? q : pad_in;

    assert_idle_oe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pad_oe |-> !idle);
    assert_idle_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        idle |=> (idle || mode != CELL_REG || pad_drive == 1'b0));
    assert_reg_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(idle) && !idle && mode == CELL_REG
            && $past(mode) == CELL_REG) |-> pad_drive == $past(sum));
    assert_fb_reg_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(idle) && mode[1]) |-> fb == $past(sum));
endmodule

// File: rtl/pal_array.sv
// Top of the programmable sum-of-products array with output cells.
// Assumes: the configuration is loaded serially with cfg_load high before
// use; outputs are meaningless until a full load has completed.
module pal_array #(
    parameter int N_IN  = 8,
    parameter int N_OUT = 4,
    parameter int N_PT  = 4,
    localparam int N_SIG    = N_IN + N_OUT,
    localparam int LIT      = 2 * N_SIG,
    localparam int AND_BITS = N_OUT * N_PT * LIT,
    localparam int TOTAL    = AND_BITS + 2 * N_OUT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load,
    input  logic             cfg_bit,
    input  logic [N_IN-1:0]  in_sig,
    input  logic [N_OUT-1:0] pad_in,
    output logic [N_OUT-1:0] pad_drive,
    output logic [N_OUT-1:0] pad_oe
);
    logic [TOTAL-1:0] cfg;
    logic [N_OUT-1:0] fb;
    logic [N_OUT-1:0] sum;
    logic [N_SIG-1:0] sig;

    pal_cfg_shift #(.TOTAL(TOTAL)) cfg_i (
        .clk  (clk),
        .rst_n(rst_n),
        .load (cfg_load),
        .din  (cfg_bit),
        .cfg  (cfg)
    );

    // Literal sources: dedicated inputs below, feedback above.
    assign sig = {fb, in_sig};

    pal_and_or #(.N_SIG(N_SIG), .N_OUT(N_OUT), .N_PT(N_PT)) array_i (
        .and_cfg(cfg[AND_BITS-1:0]),
        .sig    (sig),
        .sum    (sum)
    );

    for (genvar o = 0; o < N_OUT; o++) begin : g_cell
        pal_cell cell_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .idle     (cfg_load),
            .mode     (cfg[AND_BITS+2*o +: 2]),
            .sum      (sum[o]),
            .pad_in   (pad_in[o]),
            .pad_drive(pad_drive[o]),
            .pad_oe   (pad_oe[o]),
            .fb       (fb[o])
        );
    end

    assert_reset_quiet_R2: assert property (@(posedge clk)
        !rst_n |=> (pad_oe == '0 && pad_drive == '0));
endmodule

// File: tb/pal_array_tb.sv
module pal_array_tb_top;
    localparam int N_IN     = 8;
    localparam int N_OUT    = 4;
    localparam int N_PT     = 4;
    localparam int N_SIG    = N_IN + N_OUT;
    localparam int LIT      = 2 * N_SIG;
    localparam int AND_BITS = N_OUT * N_PT * LIT;
    localparam int TOTAL    = AND_BITS + 2 * N_OUT;

    // {in_sig[7:0], pad_in[3], exp out0, exp out2, exp out1 after edge}
    localparam int NVEC = 9;
    localparam logic [11:0] VEC [NVEC] = '{
        {8'b0000_0011, 1'b0, 1'b1, 1'b0, 1'b0},
        {8'b0001_1000, 1'b0, 1'b1, 1'b0, 1'b1},
        {8'b0000_0001, 1'b0, 1'b0, 1'b1, 1'b0},
        {8'b1100_1100, 1'b0, 1'b0, 1'b0, 1'b1},
        {8'b0010_0001, 1'b0, 1'b0, 1'b1, 1'b0},
        {8'b0011_0000, 1'b1, 1'b0, 1'b1, 1'b0},
        {8'b0000_0000, 1'b0, 1'b0, 1'b0, 1'b0},
        {8'b1111_1111, 1'b0, 1'b1, 1'b0, 1'b1},
        {8'b0000_1000, 1'b0, 1'b1, 1'b0, 1'b0}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_load = 1'b0;
    logic             cfg_bit = 1'b0;
    logic [N_IN-1:0]  in_sig = '0;
    logic [N_OUT-1:0] pad_in = '0;
    logic [N_OUT-1:0] pad_drive;
    logic [N_OUT-1:0] pad_oe;
    logic [TOTAL-1:0] cfgvec;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pal_array #(.N_IN(N_IN), .N_OUT(N_OUT), .N_PT(N_PT)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_load (cfg_load),
        .cfg_bit  (cfg_bit),
        .in_sig   (in_sig),
        .pad_in   (pad_in),
        .pad_drive(pad_drive),
        .pad_oe   (pad_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic conn(input int o, input int t, input int s, input int neg);
        cfgvec[(o*N_PT+t)*LIT + 2*s + neg] = 1'b1;
    endtask

    task automatic set_mode(input int o, input logic en, input logic sel);
        cfgvec[AND_BITS+2*o+1] = en;
        cfgvec[AND_BITS+2*o]   = sel;
    endtask

    // Serial load, first bit lands at index 0 (R1); idle checked mid-load (R3).
    task automatic load_cfg();
        for (int i = 0; i < TOTAL; i++) begin
            @(negedge clk);
            cfg_load = 1'b1;
            cfg_bit  = cfgvec[i];
            if (i == TOTAL / 2) begin
                #1;
                check("R3 oe while loading", 32'(pad_oe), 32'h0);
            end
        end
        @(negedge clk);
        cfg_load = 1'b0;
        cfg_bit  = 1'b0;
    endtask

    initial begin
        logic prev1;
        repeat (3) @(negedge clk);
        check("R2 oe after reset", 32'(pad_oe), 32'h0);
        check("R2 drive after reset", 32'(pad_drive), 32'h0);
        rst_n = 1'b1;

        // Configuration A.
        cfgvec = '0;
        conn(0, 0, 0, 0); conn(0, 0, 1, 0);
        conn(0, 1, 2, 1); conn(0, 1, 3, 0);
        conn(1, 0, 4, 0); conn(1, 0, 5, 1);
        conn(1, 1, 6, 0); conn(1, 1, 7, 0);
        conn(2, 0, N_IN + 1, 0); conn(2, 0, 0, 0);
        conn(2, 1, N_IN + 3, 0);
        conn(3, 0, 0, 0);
        set_mode(0, 1'b1, 1'b0);
        set_mode(1, 1'b1, 1'b1);
        set_mode(2, 1'b1, 1'b0);
        set_mode(3, 1'b0, 1'b0);
        load_cfg();

        // Toggle serial data with loading off: configuration must hold (R1).
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            cfg_bit = ~cfg_bit;
        end
        @(negedge clk);
        cfg_bit = 1'b0;
        prev1 = 1'b0;

        for (int e = 0; e < NVEC; e++) begin
            @(negedge clk);
            in_sig = VEC[e][11:4];
            pad_in = {VEC[e][3], 3'b000};
            #1;
            check("R8 comb out0", 32'(pad_drive[0]), 32'(VEC[e][2]));
            check("R10 feedback out2", 32'(pad_drive[2]), 32'(VEC[e][1]));
            check("R7 oe pattern", 32'(pad_oe), 32'h7);
            check("R7 pin mode drive", 32'(pad_drive[3]), 32'h0);
            check("R9 out1 before edge", 32'(pad_drive[1]), 32'(prev1));
            @(posedge clk);
            #1;
            check("R9 out1 after edge", 32'(pad_drive[1]), 32'(VEC[e][0]));
            prev1 = VEC[e][0];
        end

        // Configuration B: only one complement literal, all outputs combinational.
        cfgvec = '0;
        conn(1, 0, 0, 1);
        for (int o = 0; o < N_OUT; o++) set_mode(o, 1'b1, 1'b0);
        load_cfg();
        @(negedge clk);
        in_sig = 8'h00;
        pad_in = '0;
        #1;
        check("R4 complement literal", 32'(pad_drive), 32'h2);
        check("R8 all driven", 32'(pad_oe), 32'hF);
        @(negedge clk);
        in_sig = 8'hFF;
        pad_in = '1;
        #1;
        check("R5 empty terms zero", 32'(pad_drive), 32'h0);
        in_sig = 8'h00;
        #1;
        check("R6 out0 isolated from out1 terms", 32'(pad_drive[0]), 32'h0);

        // Reset clears the configuration.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R2 oe after second reset", 32'(pad_oe), 32'h0);
        check("R2 drive after second reset", 32'(pad_drive), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 config cleared", 32'(pad_oe), 32'h0);

        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule